// File: doc/BRIEF.md
# Frame Stream Loader with Realtime Mode

This block collects fixed-length frames of complex samples from a valid/ready input stream and parks each complete frame in an internal buffer. A processing stage takes the frame through a take/busy handshake, and the resulting frame is then streamed out on a valid/ready output. In this project the processing stage is a pass-through stub. It copies the frame into its own result store and holds it for `PROC_LAT` cycles before handing it on. The frame length, sample width and stub latency are parameters.

A static mode pin picks between two behaviours. In non-realtime mode both channels use the full handshake, and either side may stall for any number of cycles. In realtime mode the input valid only matters for the first sample of a frame. After that, every cycle in which the block is ready consumes one sample slot. A slot that the source leaves empty is filled with the most recently stored sample, and `halt_evt` is raised for that cycle. The output in realtime mode ignores `out_ready` and presents each result sample for exactly one cycle, so a consumer that does not take it loses it.

There are three state machines. The loader has the states LD_WAIT, LD_FILL and LD_FULL:
- LD_WAIT moves to LD_FILL when the first valid sample arrives.
- LD_FILL moves to LD_FULL when the last slot is written.
- LD_FULL moves back to LD_WAIT when the stage takes the frame.

The stub has the states PS_IDLE, PS_RUN and PS_HOLD:
- PS_IDLE moves to PS_RUN on a take.
- PS_RUN moves to PS_HOLD after `PROC_LAT` cycles.
- PS_HOLD moves back to PS_IDLE when the last result beat leaves.

The unloader has the states UL_IDLE and UL_SEND:
- UL_IDLE moves to UL_SEND when results are held.
- UL_SEND moves back to UL_IDLE on the last beat.

Top module: `frame_stream_loader`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1, `out_valid` is 0 and `halt_evt` is 0, and the block waits for the first sample of a frame.
- R2: In non-realtime mode a sample is stored only in a cycle where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low store nothing.
- R3: `in_ready` goes low the cycle after the last slot of a frame is stored. It stays low until the stage takes the frame and is high again in the cycle after the take.
- R4: In non-realtime mode, `out_valid` stays high with `out_re`/`out_im` unchanged for as long as `out_ready` is low.
- R5: Each output frame holds `FRAME_LEN` samples, in the order they were stored. The word is {re, im}, with re in the upper half.
- R6: In realtime mode, with `in_valid` low and no frame begun, nothing is stored, `halt_evt` stays 0 and `in_ready` stays 1, for any number of cycles.
- R7: In realtime mode, once the first sample is stored, every cycle with `in_ready` high fills one slot. If `in_valid` is low in that cycle, the slot gets a copy of the most recently stored sample.
- R8: `halt_evt` is high exactly in the realtime cycles whose slot is filled by repetition. It is never high in non-realtime mode.
- R9: In realtime mode the output ignores `out_ready`. The samples of a frame are presented on consecutive cycles, each for exactly one cycle.
- R10: In realtime mode, after a frame completes, the next sample accepted with `in_valid` high starts a new frame, even if the source meant it as part of the previous frame.
- R11: `out_valid` first rises `PROC_LAT`+1 cycles after the edge on which the stage takes the frame. The stage takes a frame only when it is idle, meaning the previous result frame has fully left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_mode | input | 1 | 1 = realtime mode, 0 = non-realtime; change only during reset |
| in_valid | input | 1 | Input sample valid |
| in_re | input | SAMPLE_W | Input sample, real part |
| in_im | input | SAMPLE_W | Input sample, imaginary part |
| in_ready | output | 1 | Block can accept a sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer ready (non-realtime only) |
| out_re | output | SAMPLE_W | Output sample, real part |
| out_im | output | SAMPLE_W | Output sample, imaginary part |
| halt_evt | output | 1 | Realtime slot filled by repetition |

## Verification
The bench stalls the output while the input is still being loaded, so a design that released the buffer too early or kept `in_ready` high while full would be caught: the output would carry samples from the next frame, or `in_ready` would mismatch the reference model. In realtime mode the source drops valid in the middle of frames. A design that waited on valid, or stored stale or zero data instead of the last sample, would show shifted or wrong output words and a missing or misplaced `halt_evt`. Frames that slip out of step test that the tail sample is taken as the head of the next frame. Holding `out_ready` low in realtime mode shows any design that still waits on the consumer, because its output would stall instead of streaming every cycle.

// File: rtl/fsl_pkg.sv
`timescale 1ns/1ps
package fsl_pkg;

    // Loader: waiting for the head sample, filling slots, holding a full frame
    typedef enum logic [1:0] {
        LD_WAIT = 2'd0,
        LD_FILL = 2'd1,
        LD_FULL = 2'd2
    } ld_state_t;

    // Processing stub: idle, counting latency, holding results for the unloader
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_RUN  = 2'd1,
        PS_HOLD = 2'd2
    } ps_state_t;

    // Unloader: idle or streaming a result frame
    typedef enum logic {
        UL_IDLE = 1'b0,
        UL_SEND = 1'b1
    } ul_state_t;

endpackage

// File: rtl/fsl_loader.sv
`timescale 1ns/1ps
module fsl_loader
    import fsl_pkg::*;
#(
    parameter int FRAME_LEN = 8,
    parameter int SAMPLE_W  = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rt_mode,
    input  logic                            in_valid,
    input  logic [SAMPLE_W-1:0]             in_re,
    input  logic [SAMPLE_W-1:0]             in_im,
    input  logic                            take,
    output logic                            in_ready,
    output logic                            halt_evt,
    output logic                            frame_full,
    output logic [FRAME_LEN*2*SAMPLE_W-1:0] frame_flat
);

    localparam int IW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam int PW = 2 * SAMPLE_W;
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);

    ld_state_t        state_q, state_d;
    logic [IW-1:0]    cnt_q;
    logic [PW-1:0]    last_q;
    logic [PW-1:0]    slot_q [FRAME_LEN];
    logic             wr_en;
    logic [PW-1:0]    wr_data;
    logic [PW-1:0]    in_word;

    assign in_word = {in_re, in_im};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_WAIT: if (in_valid) state_d = LD_FILL;
            LD_FILL: if (wr_en && cnt_q == LAST_IDX) state_d = LD_FULL;
            LD_FULL: if (take) state_d = LD_WAIT;
            default: state_d = LD_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LD_WAIT;
        else     state_q <= state_d;
    end

    // Outputs and slot write control
    always_comb begin
        wr_en      = 1'b0;
        wr_data    = in_word;
        halt_evt   = 1'b0;
        in_ready   = 1'b1;
        frame_full = 1'b0;
        unique case (state_q)
            LD_WAIT: wr_en = in_valid;
            LD_FILL: begin
                if (rt_mode) begin
                    wr_en = 1'b1;
                    if (!in_valid) begin
                        wr_data  = last_q;
                        halt_evt = 1'b1;
                    end
                end else begin
                    wr_en = in_valid;
                end
            end
            LD_FULL: begin
                in_ready   = 1'b0;
                frame_full = 1'b1;
            end
            default: ;
        endcase
    end

    // Slot index and repeat register
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (wr_en) begin
            cnt_q  <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
            last_q <= wr_data;
        end
    end

    // Frame storage
    always_ff @(posedge clk) begin
        if (wr_en) slot_q[cnt_q] <= wr_data;
    end

    generate
        for (genvar g = 0; g < FRAME_LEN; g++) begin : g_flat
            assign frame_flat[g*PW +: PW] = slot_q[g];
        end
    endgenerate

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == LD_FULL && !take) |=> (state_q == LD_FULL));

    // R7
    rt_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (rt_mode && state_q == LD_FILL) |=>
        (state_q == LD_FULL || cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/fsl_proc_stub.sv
`timescale 1ns/1ps
module fsl_proc_stub
    import fsl_pkg::*;
#(
    parameter int FRAME_LEN = 8,
    parameter int SAMPLE_W  = 16,
    parameter int PROC_LAT  = 4
) (
    input  logic                                               clk,
    input  logic                                               rst,
    input  logic                                               frame_full,
    input  logic [FRAME_LEN*2*SAMPLE_W-1:0]                    frame_flat,
    input  logic                                               res_done,
    input  logic [((FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1)-1:0] rd_idx,
    output logic                                               take,
    output logic                                               res_avail,
    output logic [2*SAMPLE_W-1:0]                              rd_data
);

    localparam int PW = 2 * SAMPLE_W;
    localparam int CW = $clog2(PROC_LAT + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(PROC_LAT - 1);

    ps_state_t     state_q, state_d;
    logic [CW-1:0] run_q;
    logic [PW-1:0] res_q [FRAME_LEN];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (frame_full) state_d = PS_RUN;
            PS_RUN:  if (run_q == RUN_LAST) state_d = PS_HOLD;
            PS_HOLD: if (res_done) state_d = PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_IDLE;
        else     state_q <= state_d;
    end

    // Outputs
    always_comb begin
        take      = 1'b0;
        res_avail = 1'b0;
        unique case (state_q)
            PS_IDLE: take = frame_full;
            PS_RUN:  ;
            PS_HOLD: res_avail = 1'b1;
            default: ;
        endcase
    end

    // Latency counter
    always_ff @(posedge clk) begin
        if (rst || state_q != PS_RUN) run_q <= '0;
        else                          run_q <= run_q + 1'b1;
    end

    // Pass-through transform: capture the frame when it is taken
    always_ff @(posedge clk) begin
        if (take) begin
            for (int i = 0; i < FRAME_LEN; i++) begin
                res_q[i] <= frame_flat[i*PW +: PW];
            end
        end
    end

    assign rd_data = res_q[rd_idx];

    // R11
    run_progress_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_RUN) |=> (state_q != PS_IDLE));

endmodule

// File: rtl/fsl_unloader.sv
`timescale 1ns/1ps
module fsl_unloader
    import fsl_pkg::*;
#(
    parameter int FRAME_LEN = 8,
    parameter int SAMPLE_W  = 16
) (
    input  logic                                               clk,
    input  logic                                               rst,
    input  logic                                               rt_mode,
    input  logic                                               res_avail,
    input  logic                                               out_ready,
    input  logic [2*SAMPLE_W-1:0]                              rd_data,
    output logic [((FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1)-1:0] rd_idx,
    output logic                                               res_done,
    output logic                                               out_valid,
    output logic [SAMPLE_W-1:0]                                out_re,
    output logic [SAMPLE_W-1:0]                                out_im
);

    localparam int IW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);

    ul_state_t     state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          beat;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UL_IDLE: if (res_avail) state_d = UL_SEND;
            UL_SEND: if (beat && idx_q == LAST_IDX) state_d = UL_IDLE;
            default: state_d = UL_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= UL_IDLE;
        else     state_q <= state_d;
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        beat      = 1'b0;
        res_done  = 1'b0;
        unique case (state_q)
            UL_IDLE: ;
            UL_SEND: begin
                out_valid = 1'b1;
                beat      = rt_mode || out_ready;
                res_done  = beat && (idx_q == LAST_IDX);
            end
            default: ;
        endcase
    end

    // Read index
    always_ff @(posedge clk) begin
        if (rst || state_q == UL_IDLE) idx_q <= '0;
        else if (beat)                 idx_q <= idx_q + 1'b1;
    end

    assign rd_idx = idx_q;
    assign out_re = rd_data[2*SAMPLE_W-1:SAMPLE_W];
    assign out_im = rd_data[SAMPLE_W-1:0];

    // R4
    hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (!rt_mode && out_valid && !out_ready) |=> (out_valid && $stable(idx_q)));

    // R9
    rt_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (rt_mode && out_valid && idx_q != LAST_IDX) |=>
        (out_valid && idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/frame_stream_loader.sv
`timescale 1ns/1ps
module frame_stream_loader #(
    parameter int FRAME_LEN = 8,
    parameter int SAMPLE_W  = 16,
    parameter int PROC_LAT  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rt_mode,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_re,
    input  logic [SAMPLE_W-1:0] in_im,
    output logic                in_ready,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_re,
    output logic [SAMPLE_W-1:0] out_im,
    output logic                halt_evt
);

    localparam int IW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam int PW = 2 * SAMPLE_W;

    logic                    take;
    logic                    frame_full;
    logic [FRAME_LEN*PW-1:0] frame_flat;
    logic                    res_avail;
    logic                    res_done;
    logic [IW-1:0]           rd_idx;
    logic [PW-1:0]           rd_data;

    fsl_loader #(
        .FRAME_LEN (FRAME_LEN),
        .SAMPLE_W  (SAMPLE_W)
    ) u_loader (
        .clk        (clk),
        .rst        (rst),
        .rt_mode    (rt_mode),
        .in_valid   (in_valid),
        .in_re      (in_re),
        .in_im      (in_im),
        .take       (take),
        .in_ready   (in_ready),
        .halt_evt   (halt_evt),
        .frame_full (frame_full),
        .frame_flat (frame_flat)
    );

    fsl_proc_stub #(
        .FRAME_LEN (FRAME_LEN),
        .SAMPLE_W  (SAMPLE_W),
        .PROC_LAT  (PROC_LAT)
    ) u_stub (
        .clk        (clk),
        .rst        (rst),
        .frame_full (frame_full),
        .frame_flat (frame_flat),
        .res_done   (res_done),
        .rd_idx     (rd_idx),
        .take       (take),
        .res_avail  (res_avail),
        .rd_data    (rd_data)
    );

    fsl_unloader #(
        .FRAME_LEN (FRAME_LEN),
        .SAMPLE_W  (SAMPLE_W)
    ) u_unloader (
        .clk       (clk),
        .rst       (rst),
        .rt_mode   (rt_mode),
        .res_avail (res_avail),
        .out_ready (out_ready),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .res_done  (res_done),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    // R3
    ready_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> in_ready);

endmodule

// File: tb/frame_stream_loader_tb.sv
`timescale 1ns/1ps
module frame_stream_loader_tb;

    localparam int N   = 8;
    localparam int SW  = 16;
    localparam int LAT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rt_mode = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_re = '0;
    logic [SW-1:0] in_im = '0;
    logic          out_ready = 1'b0;
    logic          in_ready, out_valid, halt_evt;
    logic [SW-1:0] out_re, out_im;

    always #2.5 clk = ~clk;

    frame_stream_loader #(.FRAME_LEN(N), .SAMPLE_W(SW), .PROC_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .rt_mode(rt_mode),
        .in_valid(in_valid), .in_re(in_re), .in_im(in_im), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_re(out_re), .out_im(out_im), .halt_evt(halt_evt)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    int          m_cnt, m_stage, m_run, m_oidx;
    bit          m_full, m_send;
    logic [31:0] m_last;
    logic [31:0] m_load [N];
    logic [31:0] m_held [N];
    logic [31:0] m_res  [N];

    // Stimulus state
    int          src_mode = 0;   // 0 always valid, 1 random gaps, 2 idle
    int          snk_mode = 0;   // 0 always ready, 1 random, 2 never ready
    int          src_k = 0;
    bit          acc = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int k);
        return {16'(k * 7 + 3), 16'hA000 ^ 16'(k)};
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_full = 0; m_stage = 0; m_run = 0;
        m_send = 0; m_oidx = 0; m_last = '0;
    endtask

    // Compare ports against the model, then advance the model over the next edge
    task automatic compare_and_update();
        bit          exp_rdy, exp_halt, take, beat, lastb, do_w;
        int          pre_stage;
        logic [31:0] w;
        exp_rdy  = !m_full;
        exp_halt = rt_mode && m_cnt > 0 && !m_full && !in_valid;
        chk(in_ready === exp_rdy, "R3 in_ready", 32'(in_ready), 32'(exp_rdy));
        chk(halt_evt === exp_halt, rt_mode ? "R6 R8 halt_evt" : "R8 halt_evt non-realtime",
            32'(halt_evt), 32'(exp_halt));
        chk(out_valid === m_send, rt_mode ? "R9 R11 out_valid" : "R4 R11 out_valid",
            32'(out_valid), 32'(m_send));
        if (m_send)
            chk({out_re, out_im} === m_res[m_oidx], rt_mode ? "R7 R10 out data" : "R2 R5 out data",
                {out_re, out_im}, m_res[m_oidx]);

        take  = m_full && m_stage == 0;
        beat  = m_send && (rt_mode || out_ready);
        lastb = beat && m_oidx == N - 1;
        pre_stage = m_stage;
        // output side
        if (m_send) begin
            if (lastb) m_send = 0;
            else if (beat) m_oidx++;
        end else if (pre_stage == 2) begin
            m_send = 1; m_oidx = 0;
        end
        // stage
        if (pre_stage == 0) begin
            if (take) begin m_stage = 1; m_run = 0; m_res = m_held; end
        end else if (pre_stage == 1) begin
            if (m_run == LAT - 1) m_stage = 2; else m_run++;
        end else begin
            if (lastb) m_stage = 0;
        end
        // loader
        if (m_full) begin
            if (take) m_full = 0;
        end else begin
            do_w = 0;
            w = {in_re, in_im};
            if (m_cnt == 0) do_w = in_valid;
            else if (rt_mode) begin
                do_w = 1;
                if (!in_valid) w = m_last;
            end else do_w = in_valid;
            if (do_w) begin
                m_load[m_cnt] = w;
                m_last = w;
                m_cnt++;
                if (m_cnt == N) begin
                    m_full = 1; m_held = m_load; m_cnt = 0;
                end
            end
        end
    endtask

    task automatic drive();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!in_valid || acc) begin
            if (acc) src_k++;
            case (src_mode)
                0:       in_valid = 1'b1;
                1:       in_valid = lfsr[0];
                default: in_valid = 1'b0;
            endcase
            {in_re, in_im} = word_of(src_k);
        end
        case (snk_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[3] ^ lfsr[7];
            default: out_ready = 1'b0;
        endcase
    endtask

    task automatic run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare_and_update();
            acc = in_valid && in_ready;
            @(posedge clk);
            #1;
            drive();
        end
    endtask

    task automatic do_reset(input bit rt);
        @(posedge clk);
        #1;
        rst = 1'b1; rt_mode = rt; in_valid = 1'b0; acc = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
        // R1: reset state visible at the ports
        chk(in_ready === 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
        chk(out_valid === 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk(halt_evt === 1'b0, "R1 halt_evt after reset", 32'(halt_evt), 32'd0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        // Non-realtime: smooth flow, then stalls on both sides (R2 R3 R4 R5 R11)
        do_reset(1'b0);
        src_mode = 0; snk_mode = 0; run(80);
        src_mode = 1; snk_mode = 1; run(500);
        src_mode = 0; snk_mode = 1; run(300);
        src_mode = 1; snk_mode = 0; run(200);
        // Realtime: idle before the head sample (R6)
        do_reset(1'b1);
        src_mode = 2; snk_mode = 0; run(30);
        // Realtime: full-rate source, consumer never ready (R9)
        src_mode = 0; snk_mode = 2; run(200);
        // Realtime: gapped source, repeats and halts, frame slip (R7 R8 R10)
        src_mode = 1; snk_mode = 1; run(600);
        src_mode = 2; run(60);
        src_mode = 0; run(100);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule